// File: doc/BRIEF.md
# Wide Signed/Unsigned Multiplier with Result Flags

This unit multiplies two operands of `W` bits (64 by default) and returns the double-width product as a low word and a high word. A mode input picks unsigned arithmetic or two's-complement signed arithmetic. Along with the product it reports carry and overflow, which say whether the high word carries information the low word alone cannot hold. It also reports sign, zero and parity, which are taken from the low word as for a logical result. The auxiliary-carry flag is always cleared.

Signed operation works on magnitudes. Each negative operand is replaced by its absolute value, with the most negative pattern read as the unsigned value 2^(W-1). The unsigned multiply then builds the double-width result from limb partial products, one partial product per clock cycle. The result is negated at the end when exactly one operand was negative. A low-only form forces the high word output to zero, but it still takes its carry and overflow decision from the full product. The caller must sign-extend any short immediate to `W` bits before it reaches the unit.

A request is accepted with a one-cycle `start_i` while the unit is idle. `done_o` pulses once when the result is ready, and the outputs hold until the next completion.

Top module: `wide_mul`

## Requirements
- R1: In unsigned mode (`signed_i`=0), {`prod_hi_o`,`prod_lo_o`} equals the exact 2W-bit product of the two operands read as unsigned numbers.
- R2: In signed mode (`signed_i`=1), {`prod_hi_o`,`prod_lo_o`} equals the 2W-bit two's-complement product of the operands read as signed numbers. This includes operands equal to the most negative value 1 followed by W-1 zeros.
- R3: `done_o` rises exactly (W/L)^2+1 rising clock edges after the edge that accepts `start_i`, and stays high for exactly one cycle.
- R4: In unsigned mode, `carry_o` and `ovf_o` are both 1 when the high word of the full product is nonzero, and both are 0 otherwise.
- R5: In signed mode, `carry_o` and `ovf_o` are both 0 only when every bit of the full high word equals bit W-1 of the low word; otherwise both are 1.
- R6: `sign_o` is bit W-1 of the low word, and `zero_o` is 1 exactly when the low word is zero. `parity_o` is 1 when the low min(8,W) bits of the low word hold an even number of ones. `aux_o` is 0.
- R7: With `low_only_i`=1 at acceptance, `prod_hi_o` reads zero while `prod_lo_o` and all flags are as in R1, R2 and R4 to R6.
- R8: `start_i` is ignored while a multiply is in progress, and all result outputs hold their values in every cycle in which `done_o` is low.
- R9: After reset, `done_o`, both product words and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a multiply; sampled only when idle |
| signed_i | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| low_only_i | input | 1 | 1 = high word output forced to zero |
| op_a_i | input | W | First operand |
| op_b_i | input | W | Second operand |
| done_o | output | 1 | One-cycle pulse when results are updated |
| prod_lo_o | output | W | Low word of the product |
| prod_hi_o | output | W | High word of the product (zero in low-only form) |
| carry_o | output | 1 | High word holds significant bits |
| ovf_o | output | 1 | Same decision as carry_o |
| sign_o | output | 1 | Top bit of the low word |
| zero_o | output | 1 | Low word is zero |
| parity_o | output | 1 | Even parity of the low byte of the low word |
| aux_o | output | 1 | Auxiliary carry, always cleared |

## Verification
A 6-bit instance built from 3-bit limbs is swept over every operand pair in both modes. The low-only form alternates with the parity of the operands. This sweep separates the unsigned result from the signed one on every operand with its top bit set, and it hits the most negative value against every partner. It also exposes any dropped inter-limb carry, because each partial product lands at every offset. A 64-bit instance is then driven with zero, all ones, the most negative value, mixed signs and pseudo-random pairs. These patterns check the borrow through the low word when negating, and both sides of the sign-extension test for carry and overflow. Some of these requests receive a second start while busy, to show that it is ignored and that outputs hold after the done pulse.

// File: rtl/wmul_pkg.sv
// Shared types of the wide multiplier: controller states and the flag bundle.
package wmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } wmul_state_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic sign;
        logic zero;
        logic parity;
        logic aux;
    } wmul_flags_t;

endpackage

// File: rtl/wmul_magnitude.sv
// Absolute value of one operand for the magnitude multiply.
// Assumes: in unsigned mode the operand is passed through unchanged.
// The most negative pattern maps onto itself, which read unsigned is 2^(W-1).
module wmul_magnitude #(
    parameter int W = 64
) (
    input  logic [W-1:0] value_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    // Negate only negative operands of a signed request.
    always_comb begin
        neg_o = signed_i & value_i[W-1];
        mag_o = neg_o ? (~value_i + W'(1)) : value_i;
    end
endmodule

// File: rtl/wmul_limb_engine.sv
// Sequential limb multiplier: adds one LxL partial product per cycle into a
// 2W-bit accumulator at limb offset row+col, so that carries ripple upward.
// Assumes: W is a multiple of L, and clear_i and step_i are never high together.
module wmul_limb_engine #(
    parameter int W = 64,
    parameter int L = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [2*W-1:0] acc_o,
    output logic          last_o
);
    localparam int N     = W / L;
    localparam int STEPS = N * N;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int DW    = 2 * W;

    logic [CW-1:0]   cnt_q;
    logic [L-1:0]    a_limb;
    logic [L-1:0]    b_limb;
    logic [2*L-1:0]  pp;
    logic [DW-1:0]   pp_placed;
    int unsigned     row;
    int unsigned     col;

    // Select this step's limbs and place their product at offset row+col.
    always_comb begin
        row       = 32'(cnt_q) / N;
        col       = 32'(cnt_q) % N;
        a_limb    = L'(a_i >> (row * L));
        b_limb    = L'(b_i >> (col * L));
        pp        = {{L{1'b0}}, a_limb} * {{L{1'b0}}, b_limb};
        pp_placed = DW'(pp) << ((row + col) * L);
    end

    // Accumulate one partial product per step; clear on a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            acc_o <= '0;
            cnt_q <= '0;
        end else if (step_i) begin
            acc_o <= acc_o + pp_placed;
            cnt_q <= (32'(cnt_q) == STEPS - 1) ? '0 : cnt_q + CW'(1);
        end
    end

    assign last_o = (32'(cnt_q) == STEPS - 1);
endmodule

// File: rtl/wmul_finish.sv
// Final stage: applies the sign to the magnitude product and derives the flags.
// Assumes: mag_prod_i is the complete unsigned product of the magnitudes.
module wmul_finish
    import wmul_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [2*W-1:0] mag_prod_i,
    input  logic           negate_i,
    input  logic           signed_i,
    input  logic           low_only_i,
    output logic [W-1:0]   lo_o,
    output logic [W-1:0]   hi_o,
    output wmul_flags_t    flags_o
);
    localparam int PW = (W < 8) ? W : 8;

    logic [2*W-1:0] prod;
    logic [W-1:0]   hi_full;
    logic           wide;

    // Negate the double-width result and judge whether the high word matters.
    always_comb begin
        prod    = negate_i ? (~mag_prod_i + (2*W)'(1)) : mag_prod_i;
        lo_o    = prod[W-1:0];
        hi_full = prod[2*W-1:W];
        if (signed_i) begin
            wide = (hi_full != {W{lo_o[W-1]}});
        end else begin
            wide = (hi_full != '0);
        end
        hi_o           = low_only_i ? '0 : hi_full;
        flags_o.carry  = wide;
        flags_o.ovf    = wide;
        flags_o.sign   = lo_o[W-1];
        flags_o.zero   = (lo_o == '0);
        flags_o.parity = ~^lo_o[PW-1:0];
        flags_o.aux    = 1'b0;
    end
endmodule

// File: rtl/wide_mul.sv
// Top of the wide multiplier: accepts a request when idle, runs the limb
// engine for (W/L)^2 cycles, then registers product and flags with a done pulse.
// Assumes: W is a multiple of L; operands are stable only at acceptance.
module wide_mul
    import wmul_pkg::*;
#(
    parameter int W = 64,
    parameter int L = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic         low_only_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic         done_o,
    output logic [W-1:0] prod_lo_o,
    output logic [W-1:0] prod_hi_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         sign_o,
    output logic         zero_o,
    output logic         parity_o,
    output logic         aux_o
);
    localparam int DW = 2 * W;

    wmul_state_e          state_q;
    logic [1:0][W-1:0]    raw;
    logic [1:0][W-1:0]    mag;
    logic [1:0]           neg;
    logic [W-1:0]         mag_a_q;
    logic [W-1:0]         mag_b_q;
    logic                 negate_q;
    logic                 signed_q;
    logic                 low_only_q;
    logic                 accept;
    logic                 running;
    logic                 last;
    logic [DW-1:0]        acc;
    logic [W-1:0]         fin_lo;
    logic [W-1:0]         fin_hi;
    wmul_flags_t          fin_flags;

    assign raw[0]  = op_a_i;
    assign raw[1]  = op_b_i;
    assign accept  = start_i && (state_q == ST_IDLE);
    assign running = (state_q == ST_RUN);

    // One magnitude stage per operand.
    for (genvar g = 0; g < 2; g++) begin : g_mag
        wmul_magnitude #(.W(W)) u_mag (
            .value_i  (raw[g]),
            .signed_i (signed_i),
            .mag_o    (mag[g]),
            .neg_o    (neg[g])
        );
    end

    // Controller: idle until accepted, step through partial products, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_RUN;
                ST_RUN:  if (last)   state_q <= ST_FIN;
                ST_FIN:              state_q <= ST_IDLE;
                default:             state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture magnitudes and request attributes at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a_q    <= '0;
            mag_b_q    <= '0;
            negate_q   <= 1'b0;
            signed_q   <= 1'b0;
            low_only_q <= 1'b0;
        end else if (accept) begin
            mag_a_q    <= mag[0];
            mag_b_q    <= mag[1];
            negate_q   <= neg[0] ^ neg[1];
            signed_q   <= signed_i;
            low_only_q <= low_only_i;
        end
    end

    wmul_limb_engine #(.W(W), .L(L)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (running),
        .a_i     (mag_a_q),
        .b_i     (mag_b_q),
        .acc_o   (acc),
        .last_o  (last)
    );

    wmul_finish #(.W(W)) u_finish (
        .mag_prod_i (acc),
        .negate_i   (negate_q),
        .signed_i   (signed_q),
        .low_only_i (low_only_q),
        .lo_o       (fin_lo),
        .hi_o       (fin_hi),
        .flags_o    (fin_flags)
    );

    // Register results in the finish state and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            prod_lo_o <= '0;
            prod_hi_o <= '0;
            carry_o   <= 1'b0;
            ovf_o     <= 1'b0;
            sign_o    <= 1'b0;
            zero_o    <= 1'b0;
            parity_o  <= 1'b0;
            aux_o     <= 1'b0;
        end else begin
            done_o <= (state_q == ST_FIN);
            if (state_q == ST_FIN) begin
                prod_lo_o <= fin_lo;
                prod_hi_o <= fin_hi;
                carry_o   <= fin_flags.carry;
                ovf_o     <= fin_flags.ovf;
                sign_o    <= fin_flags.sign;
                zero_o    <= fin_flags.zero;
                parity_o  <= fin_flags.parity;
                aux_o     <= fin_flags.aux;
            end
        end
    end
endmodule

// File: rtl/wide_mul_chk.sv
// Property checker for wide_mul, attached by bind. It tracks its own view of
// acceptance and latency from the ports alone.
module wide_mul_chk #(
    parameter int W = 64,
    parameter int L = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         signed_i,
    input logic         low_only_i,
    input logic         done_o,
    input logic [W-1:0] prod_lo_o,
    input logic [W-1:0] prod_hi_o,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         zero_o,
    input logic         sign_o
);
    localparam int LAT = (W / L) * (W / L) + 1;

    logic        busy_q;
    logic        cap_signed_q;
    logic        cap_low_q;
    logic [15:0] wait_q;
    logic        take;

    assign take = start_i && (!busy_q || done_o);

    // Mirror of the request in flight: mode bits and edges since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            cap_signed_q <= 1'b0;
            cap_low_q    <= 1'b0;
            wait_q       <= '0;
        end else if (take) begin
            busy_q       <= 1'b1;
            cap_signed_q <= signed_i;
            cap_low_q    <= low_only_i;
            wait_q       <= '0;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            wait_q <= wait_q + 16'd1;
        end
    end

    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_q && wait_q == 16'(LAT)));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (wait_q <= 16'(LAT)));

    p_unsigned_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cap_signed_q && !cap_low_q) |-> (carry_o == (prod_hi_o != '0)));

    p_signed_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_signed_q && !cap_low_q) |->
            (carry_o == (prod_hi_o != {W{prod_lo_o[W-1]}})));

    p_flag_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (carry_o == ovf_o));

    p_zero_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((zero_o == (prod_lo_o == '0)) && (sign_o == prod_lo_o[W-1])));

    p_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_low_q) |-> (prod_hi_o == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(prod_lo_o) && $stable(prod_hi_o) && $stable(carry_o)));
endmodule

bind wide_mul wide_mul_chk #(.W(W), .L(L)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .low_only_i (low_only_i),
    .done_o     (done_o),
    .prod_lo_o  (prod_lo_o),
    .prod_hi_o  (prod_hi_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o),
    .zero_o     (zero_o),
    .sign_o     (sign_o)
);

// File: tb/test_wide_mul.sv
// Bench: exhaustive sweep of a 6-bit instance plus directed 64-bit cases.
module test_wide_mul;
    localparam int SW = 6;
    localparam int SL = 3;
    localparam int BW = 64;
    localparam int BL = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Small instance signals
    logic          s_start = 0, s_sgn = 0, s_low = 0;
    logic [SW-1:0] s_a = '0, s_b = '0;
    logic          s_done, s_cf, s_of, s_sf, s_zf, s_pf, s_af;
    logic [SW-1:0] s_lo, s_hi;
    // Large instance signals
    logic          b_start = 0, b_sgn = 0, b_low = 0;
    logic [BW-1:0] b_a = '0, b_b = '0;
    logic          b_done, b_cf, b_of, b_sf, b_zf, b_pf, b_af;
    logic [BW-1:0] b_lo, b_hi;

    wide_mul #(.W(SW), .L(SL)) i_wide_mul_small (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .signed_i(s_sgn),
        .low_only_i(s_low), .op_a_i(s_a), .op_b_i(s_b), .done_o(s_done),
        .prod_lo_o(s_lo), .prod_hi_o(s_hi), .carry_o(s_cf), .ovf_o(s_of),
        .sign_o(s_sf), .zero_o(s_zf), .parity_o(s_pf), .aux_o(s_af));

    wide_mul #(.W(BW), .L(BL)) i_wide_mul (
        .clk(clk), .rst_n(rst_n), .start_i(b_start), .signed_i(b_sgn),
        .low_only_i(b_low), .op_a_i(b_a), .op_b_i(b_b), .done_o(b_done),
        .prod_lo_o(b_lo), .prod_hi_o(b_hi), .carry_o(b_cf), .ovf_o(b_of),
        .sign_o(b_sf), .zero_o(b_zf), .parity_o(b_pf), .aux_o(b_af));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference double-width product of w-bit operands.
    function automatic logic [127:0] ref_prod(input logic [63:0] a, input logic [63:0] b,
                                              input int w, input bit sgn);
        logic [127:0] ae, be, wmask, pmask;
        wmask = (128'd1 << w) - 128'd1;
        pmask = (w == 64) ? '1 : ((128'd1 << (2 * w)) - 128'd1);
        ae = {64'd0, a} & wmask;
        be = {64'd0, b} & wmask;
        if (sgn && ae[w-1]) ae = ae | ~wmask;
        if (sgn && be[w-1]) be = be | ~wmask;
        return (ae * be) & pmask;
    endfunction

    // One request on either instance; poke re-asserts start while busy.
    task automatic run_op(input bit big, input logic [63:0] a, input logic [63:0] b,
                          input bit sgn, input bit low, input bit poke);
        int w, k;
        bit dn;
        logic [127:0] p, wmask;
        logic [63:0] elo, ehi, ehi_full, alo, ahi;
        logic ewide, aflag[6];
        logic [63:0] hold_lo, hold_hi;
        w = big ? BW : SW;
        wmask = (128'd1 << w) - 128'd1;
        @(negedge clk);
        if (big) begin b_a = a; b_b = b; b_sgn = sgn; b_low = low; b_start = 1; end
        else begin s_a = SW'(a); s_b = SW'(b); s_sgn = sgn; s_low = low; s_start = 1; end
        k = 0;
        dn = 0;
        while (!dn && k < 20) begin
            @(negedge clk);
            k++;
            if (k == 1) begin b_start = 0; s_start = 0; end
            if (poke && k == 2) begin
                if (big) begin b_a = ~a; b_b = a; b_sgn = ~sgn; b_low = ~low; b_start = 1; end
                else begin s_a = ~SW'(a); s_b = SW'(a); s_sgn = ~sgn; s_low = ~low; s_start = 1; end
            end
            if (poke && k == 3) begin b_start = 0; s_start = 0; end
            dn = big ? b_done : s_done;
        end
        // R3: done seen at the negedge after (W/L)^2+1 edges past acceptance.
        chk(k == 6, "R3", "latency", 128'(k), 128'd6);
        p = ref_prod(a, b, w, sgn);
        elo = 64'(p & wmask);
        ehi_full = 64'(p >> w);
        ewide = sgn ? (ehi_full != (elo[w-1] ? 64'(wmask) : 64'd0)) : (ehi_full != 0);
        ehi = low ? 64'd0 : ehi_full;
        alo = big ? b_lo : 64'(s_lo);
        ahi = big ? b_hi : 64'(s_hi);
        aflag[0] = big ? b_cf : s_cf;
        aflag[1] = big ? b_of : s_of;
        aflag[2] = big ? b_sf : s_sf;
        aflag[3] = big ? b_zf : s_zf;
        aflag[4] = big ? b_pf : s_pf;
        aflag[5] = big ? b_af : s_af;
        if (sgn) chk({ahi, alo} == {ehi, elo}, low ? "R7" : "R2", "signed product",
                     {ahi, alo}, {ehi, elo});
        else     chk({ahi, alo} == {ehi, elo}, low ? "R7" : "R1", "unsigned product",
                     {ahi, alo}, {ehi, elo});
        chk(aflag[0] == ewide, sgn ? "R5" : "R4", "carry", 128'(aflag[0]), 128'(ewide));
        chk(aflag[1] == ewide, sgn ? "R5" : "R4", "overflow", 128'(aflag[1]), 128'(ewide));
        chk(aflag[2] == elo[w-1], "R6", "sign", 128'(aflag[2]), 128'(elo[w-1]));
        chk(aflag[3] == (elo == 0), "R6", "zero", 128'(aflag[3]), 128'(elo == 0));
        chk(aflag[4] == ~^elo[7:0], "R6", "parity", 128'(aflag[4]), 128'(~^elo[7:0]));
        chk(aflag[5] == 1'b0, "R6", "aux", 128'(aflag[5]), 128'd0);
        hold_lo = alo;
        hold_hi = ahi;
        @(negedge clk);
        dn = big ? b_done : s_done;
        alo = big ? b_lo : 64'(s_lo);
        ahi = big ? b_hi : 64'(s_hi);
        chk(!dn, "R3", "done single cycle", 128'(dn), 128'd0);
        chk({ahi, alo} == {hold_hi, hold_lo}, "R8", "outputs held", {ahi, alo},
            {hold_hi, hold_lo});
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] x, y;
        logic [63:0] lcg;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state on both instances.
        chk({s_done, s_lo, s_hi, s_cf, s_of, s_sf, s_zf, s_pf, s_af} == '0, "R9",
            "small reset state", 128'({s_lo, s_hi}), 128'd0);
        chk({b_done, b_cf, b_of, b_sf, b_zf, b_pf, b_af} == '0 && b_lo == 0 && b_hi == 0,
            "R9", "reset state", {b_hi, b_lo}, 128'd0);

        // R1 R2 R4 R5 R6 R7: exhaustive sweep of the 6-bit instance.
        for (int sg = 0; sg < 2; sg++) begin
            for (int ia = 0; ia < 64; ia++) begin
                for (int ib = 0; ib < 64; ib++) begin
                    run_op(1'b0, 64'(ia), 64'(ib), sg[0], ia[0] ^ ib[0], 1'b0);
                end
            end
        end

        // Directed 64-bit corners: zero, all ones, most negative, mixed signs.
        x = 64'h8000_0000_0000_0000;
        y = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int sg = 0; sg < 2; sg++) begin
            for (int lw = 0; lw < 2; lw++) begin
                run_op(1'b1, 64'd0, y, sg[0], lw[0], 1'b0);
                run_op(1'b1, y, y, sg[0], lw[0], 1'b1);
                run_op(1'b1, x, x, sg[0], lw[0], 1'b0);
                run_op(1'b1, x, y, sg[0], lw[0], 1'b1);
                run_op(1'b1, x, 64'd1, sg[0], lw[0], 1'b0);
                run_op(1'b1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFD, sg[0], lw[0], 1'b0);
                run_op(1'b1, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000, sg[0], lw[0], 1'b0);
                run_op(1'b1, 64'hFFFF_FFFF_8000_0000, 64'd2, sg[0], lw[0], 1'b0);
            end
        end
        // Pseudo-random 64-bit pairs in both modes.
        lcg = 64'h1234_5678_9ABC_DEF1;
        for (int n = 0; n < 200; n++) begin
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            x = lcg;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            y = (n % 5 == 0) ? {{32{lcg[31]}}, lcg[31:0]} : lcg;
            run_op(1'b1, x, y, n[0], n[2] & n[1], n[3]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule